// File: doc/BRIEF.md
# Entropy health gate

This block sits between a raw noise source and any post-processing stage. It takes a serial stream of raw bits, one bit per cycle at most and marked by a valid strobe, and runs two continuous health tests on it. The repetition count test looks for runs of identical bits that are too long. The adaptive proportion test looks for one bit value that is too common inside a fixed window.

Incoming bits go into a holding store the size of one proportion window. A bit is released downstream only after the whole window that contains it has passed both tests. Released bits leave one per cycle, in arrival order. If either test fails, the block latches an error code and raises an interrupt request, and it stops releasing bits. It keeps this state until a full reset or a soft reset. Both cutoffs can be programmed, and a cutoff input of zero selects a safe built-in default, so the block works without any configuration.

Top module: `entropy_health_gate`

## Requirements
- R1: After reset, `out_valid`, `out_bit`, `err_code` and `irq` are all 0.
- R2: No bit is released while its window of WIN (default 1024) accepted bits is still incomplete. `out_valid` stays 0 until the cycle after the last bit of a passing window is accepted.
- R3: When a window passes, its WIN bits are released in arrival order on WIN consecutive cycles. The first appears on the cycle after the window's last bit is accepted.
- R4: The repetition test counts consecutive identical accepted bits, the current bit included. When that count reaches the cutoff, `err_code` bit 0 is set on the edge that accepts the bit. A run one shorter than the cutoff sets no error.
- R5: The proportion test counts, within each window, the bits equal to the window's first bit, the first bit included. When that count reaches the cutoff, `err_code` bit 1 is set on the edge that accepts the bit.
- R6: A cutoff input of 0 selects the defaults: 40 for the repetition test and 589 for the proportion test.
- R7: `err_code` bits are sticky and `irq` is 1 whenever any `err_code` bit is 1. While an error is latched, `in_valid` has no effect.
- R8: From the edge that latches an error, no further bit is released. This covers bits of the failing window and any bits of an earlier passed window not yet sent.
- R9: A one-cycle `soft_rst` clears the error code, the test state and the holding store, the same as reset. Afterwards a new window is gated normally.
- R10: Cycles with `in_valid` low do not advance either test or the window. A run continues across such gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous full clear of tests, store and error |
| in_valid | input | 1 | Raw bit strobe |
| in_bit | input | 1 | Raw noise bit |
| cfg_rct_cut | input | RCT_W (8) | Repetition cutoff, 0 selects 40 |
| cfg_apt_cut | input | clog2(WIN)+1 (11) | Proportion cutoff, 0 selects 589 |
| out_valid | output | 1 | A released bit is present |
| out_bit | output | 1 | Released bit, 0 when not valid |
| err_code | output | 2 | Bit 0 repetition failure, bit 1 proportion failure |
| irq | output | 1 | Interrupt request, any error latched |

## Verification
A bit offered at a falling edge is accepted at the next rising edge. Its error effect is therefore visible at the following falling edge, and every error check samples exactly there, either one bit before a cutoff or on the cutoff bit itself. Release starts one rising edge after the last bit of a window is accepted. The bench checks that nothing has appeared at the falling edge right after that bit, and it counts released bits only after a settling margin longer than one window. In the halt case, the repetition failure is placed so that exactly five bits of the earlier window have left before the edge that latches the error. The bench then checks for that exact count.

// File: rtl/ehg_pkg.sv
package ehg_pkg;
  localparam int RCT_CUT_DEF = 40;
  localparam int APT_CUT_DEF = 589;
  localparam int ERR_RCT     = 0;
  localparam int ERR_APT     = 1;
  typedef logic [1:0] err_t;
endpackage

// File: rtl/ehg_rct.sv
module ehg_rct #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          take,
  input  logic          din,
  input  logic [CW-1:0] cut,
  output logic          fail
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] run_q, run_d;
  logic          last_q, last_d;
  logic          seen_q, seen_d;

  always_comb begin
    run_d  = run_q;
    last_d = last_q;
    seen_d = seen_q;
    if (take) begin
      seen_d = 1'b1;
      last_d = din;
      if (!seen_q || (din != last_q)) run_d = ONE;
      else if (run_q != '1)           run_d = run_q + ONE;
    end
  end

  assign fail = take && (run_d >= cut);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      last_q <= 1'b0;
      seen_q <= 1'b0;
    end else if (clr) begin
      run_q  <= '0;
      last_q <= 1'b0;
      seen_q <= 1'b0;
    end else if (take) begin
      run_q  <= run_d;
      last_q <= last_d;
      seen_q <= seen_d;
    end
  end

  // R4: once a bit has been seen the run length is at least one
  p_run_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> (run_q != '0));
endmodule

// File: rtl/ehg_apt.sv
module ehg_apt #(
  parameter int WIN = 1024,
  parameter int CW  = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          take,
  input  logic          din,
  input  logic [CW-1:0] cut,
  output logic          fail,
  output logic          win_end
);
  localparam int PW = $clog2(WIN);
  localparam logic [PW-1:0] LAST  = PW'(WIN - 1);
  localparam logic [PW-1:0] P_ONE = PW'(1);
  localparam logic [CW-1:0] C_ONE = CW'(1);

  logic [PW-1:0] pos_q, pos_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ref_q, ref_d;
  logic          first;

  always_comb begin
    first = (pos_q == '0);
    ref_d = first ? din : ref_q;
    if (first)              cnt_d = C_ONE;
    else if (din == ref_q)  cnt_d = cnt_q + C_ONE;
    else                    cnt_d = cnt_q;
    pos_d = (pos_q == LAST) ? '0 : pos_q + P_ONE;
  end

  assign fail    = take && (cnt_d >= cut);
  assign win_end = take && (pos_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      cnt_q <= '0;
      ref_q <= 1'b0;
    end else if (clr) begin
      pos_q <= '0;
      cnt_q <= '0;
      ref_q <= 1'b0;
    end else if (take) begin
      pos_q <= pos_d;
      cnt_q <= cnt_d;
      ref_q <= ref_d;
    end
  end

  // R5: inside a window the match count never exceeds the bits seen
  p_cnt_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q != '0) |-> ((cnt_q != '0) && (cnt_q <= CW'(pos_q))));
endmodule

// File: rtl/ehg_hold.sv
module ehg_hold #(
  parameter int WIN = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic take,
  input  logic din,
  input  logic pass,
  input  logic halt,
  output logic out_valid,
  output logic out_bit
);
  localparam int AW = $clog2(WIN);
  localparam logic [AW-1:0] LAST  = AW'(WIN - 1);
  localparam logic [AW-1:0] A_ONE = AW'(1);
  localparam logic [AW:0]   K_ONE = (AW+1)'(1);
  localparam logic [AW:0]   K_WIN = (AW+1)'(WIN);

  logic [WIN-1:0] store;
  logic [AW-1:0]  wr_q, wr_d, rd_q, rd_d;
  logic [AW:0]    credit_q, credit_d;
  logic           rel;
  logic           ov_q, ob_q;

  always_comb begin
    rel      = (credit_q != '0) && !halt;
    wr_d     = (wr_q == LAST) ? '0 : wr_q + A_ONE;
    rd_d     = (rd_q == LAST) ? '0 : rd_q + A_ONE;
    credit_d = credit_q;
    if (rel)  credit_d = credit_d - K_ONE;
    if (pass) credit_d = credit_d + K_WIN;
  end

  always_ff @(posedge clk) begin
    if (take) store[wr_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q     <= '0;
      rd_q     <= '0;
      credit_q <= '0;
      ov_q     <= 1'b0;
      ob_q     <= 1'b0;
    end else if (clr) begin
      wr_q     <= '0;
      rd_q     <= '0;
      credit_q <= '0;
      ov_q     <= 1'b0;
      ob_q     <= 1'b0;
    end else begin
      if (take) wr_q <= wr_d;
      if (rel)  rd_q <= rd_d;
      credit_q <= credit_d;
      ov_q     <= rel;
      ob_q     <= rel ? store[rd_q] : 1'b0;
    end
  end

  assign out_valid = ov_q;
  assign out_bit   = ob_q;

  // R3: released credit never exceeds one window
  p_credit_le_win_r3: assert property (@(posedge clk) disable iff (!rst_n)
    credit_q <= K_WIN);
  // R2: a bit leaves only when a passed window granted credit
  p_out_needs_credit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(credit_q != '0));
endmodule

// File: rtl/entropy_health_gate.sv
module entropy_health_gate
  import ehg_pkg::*;
#(
  parameter int WIN     = 1024,
  parameter int RCT_W   = 8,
  parameter int RCT_DEF = RCT_CUT_DEF,
  parameter int APT_DEF = APT_CUT_DEF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    soft_rst,
  input  logic                    in_valid,
  input  logic                    in_bit,
  input  logic [RCT_W-1:0]        cfg_rct_cut,
  input  logic [$clog2(WIN):0]    cfg_apt_cut,
  output logic                    out_valid,
  output logic                    out_bit,
  output logic [1:0]              err_code,
  output logic                    irq
);
  localparam int APT_W = $clog2(WIN) + 1;

  logic [RCT_W-1:0] rct_cut;
  logic [APT_W-1:0] apt_cut;
  logic             take, rct_fail, apt_fail, win_end, pass, halt;
  err_t             err_q, err_d;

  always_comb begin
    rct_cut = (cfg_rct_cut == '0) ? RCT_W'(RCT_DEF) : cfg_rct_cut;
    apt_cut = (cfg_apt_cut == '0) ? APT_W'(APT_DEF) : cfg_apt_cut;
    take    = in_valid && (err_q == '0) && !soft_rst;
    pass    = win_end && !rct_fail && !apt_fail;
    halt    = (err_q != '0) || rct_fail || apt_fail;
    err_d   = err_q;
    err_d[ERR_RCT] = err_q[ERR_RCT] | rct_fail;
    err_d[ERR_APT] = err_q[ERR_APT] | apt_fail;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        err_q <= '0;
    else if (soft_rst) err_q <= '0;
    else               err_q <= err_d;
  end

  ehg_rct #(.CW(RCT_W)) u_rct (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .take(take),
    .din(in_bit), .cut(rct_cut), .fail(rct_fail)
  );

  ehg_apt #(.WIN(WIN), .CW(APT_W)) u_apt (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .take(take),
    .din(in_bit), .cut(apt_cut), .fail(apt_fail), .win_end(win_end)
  );

  ehg_hold #(.WIN(WIN)) u_hold (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .take(take),
    .din(in_bit), .pass(pass), .halt(halt),
    .out_valid(out_valid), .out_bit(out_bit)
  );

  assign err_code = err_q;
  assign irq      = (err_q != '0);

  // R7: latched error bits are never dropped without a soft reset
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_code != '0) && !soft_rst) |=> ((err_code & $past(err_code)) == $past(err_code)));
  // R8: nothing is released once an error is latched
  p_quiet_after_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code != '0) |=> !out_valid);
  // R9: soft reset leaves a clean output state
  p_soft_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> ((err_code == '0) && !out_valid && !irq));
endmodule

// File: tb/entropy_health_gate_tb.sv
module entropy_health_gate_tb;
  localparam int WIN = 1024;

  logic        clk = 1'b0;
  logic        rst_n, soft_rst, in_valid, in_bit;
  logic [7:0]  cfg_rct_cut;
  logic [10:0] cfg_apt_cut;
  logic        out_valid, out_bit, irq;
  logic [1:0]  err_code;

  int nchk = 0, nbad = 0;
  int cyc = 0, ncap = 0, first_cyc = 0, last_cyc = 0;
  logic cap [0:2047];

  always #5 clk = ~clk;

  entropy_health_gate u_dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .in_valid(in_valid),
    .in_bit(in_bit), .cfg_rct_cut(cfg_rct_cut), .cfg_apt_cut(cfg_apt_cut),
    .out_valid(out_valid), .out_bit(out_bit), .err_code(err_code), .irq(irq)
  );

  always @(negedge clk) begin
    cyc++;
    if (out_valid) begin
      if (ncap < 2048) cap[ncap] = out_bit;
      if (ncap == 0) first_cyc = cyc;
      last_cyc = cyc;
      ncap++;
    end
  end

  function automatic logic pat(input int i);
    return logic'(i[0] ^ i[4]);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; soft_rst = 1'b0; in_valid = 1'b0; in_bit = 1'b0;
    cfg_rct_cut = '0; cfg_apt_cut = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    ncap = 0;
  endtask

  task automatic send(input logic b);
    @(negedge clk);
    in_valid = 1'b1;
    in_bit   = b;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic int mism(input int n);
    int m = 0;
    for (int i = 0; i < n; i++) if (cap[i] != pat(i)) m++;
    return m;
  endfunction

  task automatic t_reset();
    do_reset();
    check("R1 out_valid", int'(out_valid), 0);
    check("R1 out_bit", int'(out_bit), 0);
    check("R1 err_code", int'(err_code), 0);
    check("R1 irq", int'(irq), 0);
  endtask

  task automatic t_window();
    do_reset();
    for (int i = 0; i < WIN; i++) begin
      if (i % 7 == 3) idle();   // R10: gaps must not disturb the window
      send(pat(i));
    end
    idle();
    check("R2 no release before window end", ncap, 0);
    repeat (WIN + 6) @(negedge clk);
    check("R3 released count", ncap, WIN);
    check("R3 order mismatches", mism(WIN), 0);
    check("R3 consecutive span", last_cyc - first_cyc, WIN - 1);
    check("R10 no error with gaps", int'(err_code), 0);
  endtask

  task automatic t_rct_prog();
    do_reset();
    cfg_rct_cut = 8'd5;
    send(1'b0);
    for (int i = 0; i < 4; i++) send(1'b1);
    idle();
    check("R4 run below cutoff", int'(err_code), 0);
    send(1'b1);                  // R10: run continues across the gap
    idle();
    check("R4 run at cutoff", int'(err_code), 1);
    check("R7 irq", int'(irq), 1);
    for (int i = 0; i < 10; i++) send(logic'(i[0]));
    idle();
    check("R7 sticky error", int'(err_code), 1);
    check("R8 nothing released", ncap, 0);
  endtask

  task automatic t_rct_def();
    do_reset();
    for (int i = 0; i < 39; i++) send(1'b1);
    idle();
    check("R6 rct default minus one", int'(err_code), 0);
    send(1'b1);
    idle();
    check("R6 rct default 40", int'(err_code), 1);
  endtask

  task automatic t_apt_prog();
    do_reset();
    cfg_apt_cut = 11'd10;
    for (int i = 0; i < 18; i++) send(logic'(i[0]));
    idle();
    check("R5 apt below cutoff", int'(err_code), 0);
    send(1'b0);
    idle();
    check("R5 apt at cutoff", int'(err_code), 2);
  endtask

  task automatic t_apt_def();
    do_reset();
    for (int i = 0; i < 784; i++) send(logic'(i % 4 != 3));
    idle();
    check("R6 apt default minus one", int'(err_code), 0);
    send(1'b1);
    idle();
    check("R6 apt default 589", int'(err_code), 2);
    check("R7 irq apt", int'(irq), 1);
  endtask

  task automatic t_halt();
    do_reset();
    cfg_rct_cut = 8'd6;
    for (int i = 0; i < WIN; i++) send(pat(i));
    for (int i = 0; i < 6; i++) send(1'b1);
    idle();
    repeat (50) @(negedge clk);
    check("R8 partial release count", ncap, 5);
    check("R8 partial release order", mism(5), 0);
    check("R8 error latched", int'(err_code), 1);
  endtask

  task automatic t_soft();
    @(negedge clk);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    check("R9 err cleared", int'(err_code), 0);
    check("R9 irq cleared", int'(irq), 0);
    check("R9 out_valid low", int'(out_valid), 0);
    cfg_rct_cut = '0;
    ncap = 0;
    for (int i = 0; i < WIN; i++) send(pat(i));
    idle();
    repeat (WIN + 6) @(negedge clk);
    check("R9 window after soft reset", ncap, WIN);
    check("R9 order after soft reset", mism(WIN), 0);
  endtask

  initial begin
    t_reset();
    t_window();
    t_rct_prog();
    t_rct_def();
    t_apt_prog();
    t_apt_def();
    t_halt();
    t_soft();
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    #1000000;
    nchk++;
    nbad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule